// File: doc/BRIEF.md
# Serial Flash Read Fetcher (single and dual data lane)

This block is the host side of a serial flash read path. A request carries a 24-bit start address, a byte count and a lane select. The block then lowers chip select and sends the read opcode and the address on the serial command line. For the two-lane read it also sends one filler byte. It then clocks data back, either one bit per SCK cycle on the flash data-out line or two bits per cycle on both I/O lines. Each assembled byte is handed downstream on a valid/ready stream.

SCK follows SPI mode 0. It idles low, the flash samples on the rising edge, and the outgoing bit changes only while SCK is low. Each SCK half period lasts a fixed number of system clocks set by a parameter. Downstream backpressure stretches the low phase of SCK, so no byte is ever dropped. An abort input ends a transfer at the next SCK-low point and discards any partly assembled byte. Between transfers, chip select stays high for a guaranteed number of system clocks.

Top module: `flash_fetch`

## Requirements
- R1: In single-lane mode, the command line carries opcode 0x03 MSB first, then A23..A0 MSB first, sampled by the flash on SCK rising edges. Data bits are taken on io1_i at each rising edge, MSB first, eight rises per byte, and io0_i is ignored. A transfer of N bytes uses exactly 32+8N SCK rises.
- R2: In dual-lane mode, the opcode is 0x3B, followed by A23..A0 and then 8 filler bits. Each rising edge then takes two data bits: io1_i is the higher bit and io0_i the lower, starting with bits 7 and 6. A transfer of N bytes uses exactly 40+4N SCK rises.
- R3: SCK is low whenever cs_n is high, and mosi_o does not change while SCK is high.
- R4: mosi_oe is high only while header bits (opcode, address, filler) are being sent. It goes low at the SCK falling edge that follows the last header bit, and stays low during data and while cs_n is high.
- R5: Every SCK high phase lasts exactly HALF_PER system clocks, and every low phase lasts at least HALF_PER.
- R6: Bytes appear on dout_data in address order, one per dout_valid/dout_ready handshake, exactly the requested count. While dout_valid is high and dout_ready is low, dout_valid and dout_data hold.
- R7: While dout_valid is high and dout_ready is low, SCK does not rise.
- R8: An abort pulse during a transfer raises cs_n within 2*HALF_PER+1 system clocks, with SCK low. A partly assembled byte is discarded, so the next transfer returns correct data.
- R9: Between consecutive transfers, cs_n stays high for at least CS_GAP system clocks.
- R10: After reset, cs_n=1, sck=0, mosi_oe=0, dout_valid=0, and req_ready=1. req_ready is high only while cs_n is high and the block is idle.
- R11: A request with a byte count of 0 sends only the header (32 or 40 rises), returns no byte, and then raises cs_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes to fetch |
| req_dual | input | 1 | 1 = two data lanes, 0 = one data lane |
| abort | input | 1 | End the running transfer early |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Command/address line (I/O0 when driven) |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| io0_i | input | 1 | Lower data lane (I/O0) |
| io1_i | input | 1 | Flash data-out line, upper data lane (I/O1) |
| dout_valid | output | 1 | Assembled byte available |
| dout_ready | input | 1 | Downstream accepts the byte |
| dout_data | output | 8 | Assembled byte |

## Verification
A behavioural flash on the bench decodes the opcode and address from the SCK edges and drives a byte pattern computed from the address. In single-lane runs it toggles io0_i, so a design that mixed in the wrong lane or the wrong bit order produces wrong bytes. Reads are run in both lane modes with an always-ready consumer and with a pseudo-random ready pattern. The first case pins the exact SCK rise count per byte. The second exercises the hold and stretch rules. A wrap across the top of the array, zero-length reads and two requests issued back to back separate header length from data length and test the chip-select gap. An abort in the middle of a byte, followed by a fresh read, shows whether stale partial bits leak into the next transfer.

// File: rtl/flash_fetch_pkg.sv
package flash_fetch_pkg;

    localparam int ADDR_W     = 24;
    localparam int CMD_BITS   = 8;
    localparam int FILL_BITS  = 8;
    localparam int HDR_MAX    = CMD_BITS + ADDR_W + FILL_BITS;
    localparam int HDR_W      = $clog2(HDR_MAX + 1);

    localparam logic [7:0] OPC_ONE_LANE = 8'h03;
    localparam logic [7:0] OPC_TWO_LANE = 8'h3B;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_DATA,
        PH_GAP
    } phase_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              dual;
    } req_t;

    function automatic logic [7:0] opcode_for(input logic dual);
        return dual ? OPC_TWO_LANE : OPC_ONE_LANE;
    endfunction

    function automatic logic [HDR_W-1:0] header_bits(input logic dual);
        return dual ? HDR_W'(HDR_MAX) : HDR_W'(CMD_BITS + ADDR_W);
    endfunction

    function automatic logic [3:0] lane_step(input logic dual);
        return dual ? 4'd2 : 4'd1;
    endfunction

endpackage

// File: rtl/flash_fetch_tick.sv
module flash_fetch_tick #(
    parameter int HALF_PER = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/flash_fetch_hdr.sv
module flash_fetch_hdr
    import flash_fetch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic shift,
    input  req_t req,
    output logic bit_o
);
    logic [HDR_MAX-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= {opcode_for(req.dual), req.addr, {FILL_BITS{1'b0}}};
        end else if (shift) begin
            sr <= {sr[HDR_MAX-2:0], 1'b0};
        end
    end

    assign bit_o = sr[HDR_MAX-1];
endmodule

// File: rtl/flash_fetch_capture.sv
module flash_fetch_capture
    import flash_fetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       sample,
    input  logic       dual,
    input  logic       lane_hi,
    input  logic       lane_lo,
    output logic       done,
    output logic [7:0] byte_o
);
    logic [7:0] sh;
    logic [3:0] cnt;
    logic [7:0] nxt;
    logic [3:0] ncnt;

    always_comb begin
        if (dual) begin
            nxt = {sh[5:0], lane_hi, lane_lo};
        end else begin
            nxt = {sh[6:0], lane_hi};
        end
        ncnt = cnt + lane_step(dual);
    end

    assign done   = sample && (ncnt == 4'd8);
    assign byte_o = nxt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh  <= '0;
            cnt <= '0;
        end else if (sample) begin
            sh  <= nxt;
            cnt <= done ? 4'd0 : ncnt;
        end
    end
endmodule

// File: rtl/flash_fetch.sv
module flash_fetch
    import flash_fetch_pkg::*;
#(
    parameter int HALF_PER = 2,
    parameter int CS_GAP   = 5,
    parameter int LEN_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_dual,
    input  logic             abort,
    output logic             cs_n,
    output logic             sck,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             io0_i,
    input  logic             io1_i,
    output logic             dout_valid,
    input  logic             dout_ready,
    output logic [7:0]       dout_data
);
    localparam int GW = $clog2(CS_GAP + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);

    phase_t           ph;
    logic             active;
    logic             tick;
    logic             sck_q;
    logic [HDR_W-1:0] hdr_left;
    logic [LEN_W-1:0] left;
    logic             dual_q;
    logic             abort_pend;
    logic [GW-1:0]    gcnt;
    logic             valid_q;
    logic [7:0]       data_q;

    logic             low_tick;
    logic             stall;
    logic             finish;
    logic             rise;
    logic             fall;
    logic             sample;
    logic             start;
    logic             hdr_bit;
    logic             cap_done;
    logic [7:0]       cap_byte;
    req_t             rq;

    assign active   = (ph == PH_HDR) || (ph == PH_DATA);
    assign start    = (ph == PH_IDLE) && req_valid;
    assign low_tick = tick && !sck_q;
    assign stall    = valid_q && !dout_ready;
    assign finish   = low_tick && (abort_pend || abort ||
                                   ((ph == PH_DATA) && (left == '0)));
    assign rise     = low_tick && !finish && !stall;
    assign fall     = tick && sck_q;
    assign sample   = rise && (ph == PH_DATA);
    assign rq       = '{addr: req_addr, dual: req_dual};

    flash_fetch_tick #(.HALF_PER(HALF_PER)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .tick (tick)
    );

    flash_fetch_hdr u_hdr (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .shift (fall && (ph == PH_HDR)),
        .req   (rq),
        .bit_o (hdr_bit)
    );

    flash_fetch_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .clear   (!active),
        .sample  (sample),
        .dual    (dual_q),
        .lane_hi (io1_i),
        .lane_lo (io0_i),
        .done    (cap_done),
        .byte_o  (cap_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            sck_q      <= 1'b0;
            hdr_left   <= '0;
            left       <= '0;
            dual_q     <= 1'b0;
            abort_pend <= 1'b0;
            gcnt       <= '0;
            valid_q    <= 1'b0;
            data_q     <= '0;
        end else begin
            if (valid_q && dout_ready) begin
                valid_q <= 1'b0;
            end
            if (cap_done) begin
                valid_q <= 1'b1;
                data_q  <= cap_byte;
                left    <= left - 1'b1;
            end
            case (ph)
                PH_IDLE: begin
                    if (req_valid) begin
                        ph         <= PH_HDR;
                        hdr_left   <= header_bits(req_dual);
                        left       <= req_len;
                        dual_q     <= req_dual;
                        abort_pend <= 1'b0;
                    end
                end
                PH_HDR, PH_DATA: begin
                    if (abort) begin
                        abort_pend <= 1'b1;
                    end
                    if (finish) begin
                        ph         <= PH_GAP;
                        gcnt       <= '0;
                        abort_pend <= 1'b0;
                    end else if (rise) begin
                        sck_q <= 1'b1;
                    end else if (fall) begin
                        sck_q <= 1'b0;
                        if (ph == PH_HDR) begin
                            hdr_left <= hdr_left - 1'b1;
                            if (hdr_left == HDR_W'(1)) begin
                                ph <= PH_DATA;
                            end
                        end
                    end
                end
                PH_GAP: begin
                    if (gcnt == GAP_LAST) begin
                        ph <= PH_IDLE;
                    end else begin
                        gcnt <= gcnt + GW'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign cs_n       = !active;
    assign sck        = sck_q;
    assign mosi_o     = (ph == PH_HDR) ? hdr_bit : 1'b0;
    assign mosi_oe    = (ph == PH_HDR);
    assign req_ready  = (ph == PH_IDLE);
    assign dout_valid = valid_q;
    assign dout_data  = data_q;
endmodule

// File: rtl/flash_fetch_chk.sv
module flash_fetch_chk #(
    parameter int HALF_PER = 2,
    parameter int CS_GAP   = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sck,
    input logic       mosi_o,
    input logic       mosi_oe,
    input logic       req_ready,
    input logic       dout_valid,
    input logic       dout_ready,
    input logic [7:0] dout_data
);
    logic [15:0] hi_cnt;
    logic [15:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt  <= '0;
            gap_cnt <= 16'(CS_GAP);
        end else begin
            hi_cnt  <= sck ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
            gap_cnt <= cs_n ? ((gap_cnt == 16'hFFFF) ? gap_cnt : gap_cnt + 16'd1) : 16'd0;
        end
    end

    // R3
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R3
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi_o));

    // R4
    oe_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !mosi_oe);

    // R5
    half_period_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sck) |-> (hi_cnt == 16'(HALF_PER)));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));

    // R7
    stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_valid && !dout_ready && !sck) |=> !sck);

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (gap_cnt >= 16'(CS_GAP)));

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cs_n);
endmodule

bind flash_fetch flash_fetch_chk #(.HALF_PER(HALF_PER), .CS_GAP(CS_GAP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sck        (sck),
    .mosi_o     (mosi_o),
    .mosi_oe    (mosi_oe),
    .req_ready  (req_ready),
    .dout_valid (dout_valid),
    .dout_ready (dout_ready),
    .dout_data  (dout_data)
);

// File: tb/sim_flash_fetch.sv
`timescale 1ns/1ps
module sim_flash_fetch;
    localparam int HP  = 2;
    localparam int GAP = 5;
    localparam int LW  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [23:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_dual = 1'b0;
    logic          abort = 1'b0;
    logic          cs_n, sck, mosi_o, mosi_oe;
    logic          io0_i = 1'b0;
    logic          io1_i = 1'b0;
    logic          dout_valid;
    logic          dout_ready = 1'b1;
    logic [7:0]    dout_data;

    always #10 clk = ~clk;

    flash_fetch #(.HALF_PER(HP), .CS_GAP(GAP), .LEN_W(LW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_dual(req_dual), .abort(abort),
        .cs_n(cs_n), .sck(sck), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .io0_i(io0_i), .io1_i(io1_i), .dout_valid(dout_valid),
        .dout_ready(dout_ready), .dout_data(dout_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fmem(input logic [20:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ {3'b000, a[20:16]} ^ 8'h5A;
    endfunction

    // behavioural flash
    int          m_bits = 0;
    int          m_rises = 0;
    logic [7:0]  m_op = '0;
    logic [23:0] m_addr = '0;
    bit          m_data = 0;
    logic [20:0] m_a = '0;
    int          m_bp = 0;
    int          log_op[$];
    int          log_addr[$];
    int          log_rises[$];

    always @(posedge sck) begin
        if (!cs_n) begin
            m_rises++;
            if (m_bits < 8) m_op = {m_op[6:0], mosi_o};
            else if (m_bits < 32) m_addr = {m_addr[22:0], mosi_o};
            m_bits++;
        end
    end

    always @(negedge sck) begin
        logic [7:0] b;
        if (cs_n == 1'b0 && m_bits >= ((m_op == 8'h3B) ? 40 : 32)) begin
            if (!m_data) begin
                m_data = 1;
                m_a    = m_addr[20:0];
                m_bp   = 0;
            end
            b = fmem(m_a);
            if (m_op == 8'h3B) begin
                io1_i = b[7-m_bp];
                io0_i = b[6-m_bp];
                m_bp += 2;
            end else begin
                io1_i = b[7-m_bp];
                io0_i = ~io0_i;
                m_bp += 1;
            end
            if (m_bp >= 8) begin
                m_bp = 0;
                m_a  = m_a + 21'd1;
            end
        end
    end

    always @(posedge cs_n) begin
        if (!rst) begin
            log_op.push_back(int'(m_op));
            log_addr.push_back(int'(m_addr));
            log_rises.push_back(m_rises);
        end
        m_bits = 0; m_rises = 0; m_data = 0; m_bp = 0;
    end

    // reference expectations
    logic [7:0] exp_q[$];
    int         e_op[$];
    int         e_addr[$];
    int         e_rises[$];

    int         rdy_mode = 0;
    logic [15:0] lf = 16'hACE1;
    bit         p_stall = 0, p_hold = 0, p_cs = 1, p_sck = 0, p_mosi = 0;
    logic [7:0] p_data = '0;
    int         hi_run = 100, last_gap = 100, min_gap = 100;
    int         sck_hi = 0, sck_lo = 0;
    int         rx_cnt = 0, stall_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            case (rdy_mode)
                0: dout_ready = 1'b1;
                default: begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    dout_ready = lf[0] & lf[3];
                end
            endcase
            chk(cs_n == 1'b0 || sck == 1'b0, "R3", "sck high with cs_n high", sck, 0);
            if (sck && p_sck)
                chk(mosi_o == p_mosi, "R3", "mosi changed while sck high", mosi_o, p_mosi);
            chk(mosi_oe == (!cs_n && !m_data), "R4", "mosi_oe", mosi_oe, (!cs_n && !m_data));
            if (p_stall) chk(sck == 1'b0, "R7", "sck rose while stalled", sck, 0);
            if (p_hold)
                chk(dout_valid && dout_data == p_data, "R6", "held byte", dout_data, p_data);
            if (dout_valid && !dout_ready && !cs_n) stall_seen++;
            if (dout_valid && dout_ready) begin
                rx_cnt++;
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected byte", dout_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(dout_data == e, "R1/R2", "byte value", dout_data, e);
                end
            end
            if (sck) begin
                if (!p_sck && !cs_n) chk(sck_lo >= HP, "R5", "low phase", sck_lo, HP);
                sck_hi++; sck_lo = 0;
            end else begin
                if (p_sck) chk(sck_hi == HP, "R5", "high phase", sck_hi, HP);
                sck_lo++; sck_hi = 0;
            end
            if (cs_n) hi_run++;
            else begin
                if (p_cs) begin
                    chk(hi_run >= GAP, "R9", "cs_n high gap", hi_run, GAP);
                    last_gap = hi_run;
                    if (hi_run < min_gap) min_gap = hi_run;
                end
                hi_run = 0;
            end
            p_stall = dout_valid && !dout_ready && !sck;
            p_hold  = dout_valid && !dout_ready;
            p_data  = dout_data;
            p_cs    = cs_n;
            p_sck   = sck;
            p_mosi  = mosi_o;
        end
    end

    task automatic start_req(input logic [23:0] a, input int n, input bit d, input bit skip);
        for (int i = 0; i < n; i++) exp_q.push_back(fmem(21'(a + 24'(i))));
        e_op.push_back(d ? 8'h3B : 8'h03);
        e_addr.push_back(int'(a));
        e_rises.push_back(skip ? -1 : (d ? 40 + 4 * n : 32 + 8 * n));
        @(negedge clk);
        req_addr = a; req_len = LW'(n); req_dual = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k;
        k = 0;
        @(negedge clk);
        while (!(cs_n && req_ready && !dout_valid && exp_q.size() == 0) && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(k < 20000, tag, "transfer completion", k, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_logs(input string tag);
        while (e_op.size() != 0) begin
            int eo, ea, er;
            eo = e_op.pop_front(); ea = e_addr.pop_front(); er = e_rises.pop_front();
            if (log_op.size() == 0) begin
                chk(0, tag, "missing transaction", 0, eo);
            end else begin
                int lo, la, lr;
                lo = log_op.pop_front(); la = log_addr.pop_front(); lr = log_rises.pop_front();
                chk(lo == eo, tag, "opcode", lo, eo);
                chk(la == ea, tag, "address", la, ea);
                if (er >= 0) chk(lr == er, tag, "sck rise count", lr, er);
            end
        end
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int k;
        int rx0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(cs_n == 1'b1, "R10", "cs_n after reset", cs_n, 1);
        chk(sck == 1'b0, "R10", "sck after reset", sck, 0);
        chk(mosi_oe == 1'b0, "R10", "mosi_oe after reset", mosi_oe, 0);
        chk(dout_valid == 1'b0, "R10", "dout_valid after reset", dout_valid, 0);
        chk(req_ready == 1'b1, "R10", "req_ready after reset", req_ready, 1);

        // R1 single lane, free-flowing
        start_req(24'h012345, 3, 0, 0);
        chk(cs_n == 1'b0 && req_ready == 1'b0, "R10", "busy while active", req_ready, 0);
        wait_done("R1");
        check_logs("R1");

        // R2 dual lane, free-flowing
        start_req(24'h0ABCDE, 5, 1, 0);
        wait_done("R2");
        check_logs("R2");

        // R2 wrap over the top of the array
        start_req(24'h1FFFFE, 4, 1, 0);
        wait_done("R2");
        check_logs("R2");

        // R6 R7 backpressure in both modes
        rdy_mode = 1;
        stall_seen = 0;
        start_req(24'h054321, 6, 1, 0);
        wait_done("R6");
        check_logs("R6");
        chk(stall_seen > 0, "R7", "stall exercised", stall_seen, 1);
        start_req(24'h100F00, 4, 0, 0);
        wait_done("R6");
        check_logs("R6");
        rdy_mode = 0;

        // R11 zero length
        rx0 = rx_cnt;
        start_req(24'h000777, 0, 0, 0);
        wait_done("R11");
        start_req(24'h000888, 0, 1, 0);
        wait_done("R11");
        check_logs("R11");
        chk(rx_cnt == rx0, "R11", "no bytes for zero length", rx_cnt - rx0, 0);

        // R9 back-to-back requests
        min_gap = 100;
        start_req(24'h003000, 2, 0, 0);
        start_req(24'h004000, 2, 1, 0);
        wait_done("R9");
        check_logs("R9");
        chk(last_gap >= GAP && last_gap <= GAP + 3, "R9", "tight gap", last_gap, GAP);

        // R8 abort in the middle of a byte
        rx0 = rx_cnt;
        start_req(24'h020000, 8, 1, 1);
        while (rx_cnt < rx0 + 2) @(negedge clk);
        repeat (3) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        k = 1;
        while (!cs_n && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(k <= 2 * HP + 1, "R8", "cycles to cs_n high", k, 2 * HP + 1);
        chk(sck == 1'b0, "R8", "sck low at abort end", sck, 0);
        repeat (4) @(negedge clk);
        chk(rx_cnt - rx0 >= 2 && rx_cnt - rx0 <= 3, "R8", "bytes before abort", rx_cnt - rx0, 2);
        exp_q.delete();
        check_logs("R8");
        start_req(24'h030303, 3, 1, 0);
        wait_done("R8");
        check_logs("R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule